// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor Core

This core executes a stream of one-address instructions out of a single word-wide memory port. Its state consists of a program counter, a memory address register, a memory data register, an instruction register and one accumulator. Every memory access passes through the address and data registers in explicit steps. The core drives the address, a read or a write strobe and the write data from those registers. It then holds them steady until the memory answers with a ready pulse.

An instruction is one 32-bit word. The top eight bits select the operation and the low 24 bits name a memory location or jump target. The core repeats a fixed loop until it meets a halt or an undefined operation code, then stays halted until reset. The loop fetches the word at the program counter into the data register, copies it to the instruction register, advances the program counter and decodes. It then performs an operand read or a result write if the operation needs one.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it, `halted`, `illegal_op` and `mem_wr` are 0. The first read the core issues after reset is at address `START_ADDR`, and the accumulator starts at zero.
- R2: An instruction fetch raises `mem_rd` with `mem_addr` equal to the program counter, and the returned word decides what the core does next.
- R3: Without a jump, instruction fetches go to consecutive addresses, each one greater than the last.
- R4: Instruction bits [31:24] hold the operation code and bits [23:0] hold the operand address that appears on `mem_addr` for a memory operand.
- R5: Opcode 0x01 (load) reads the word at the operand address into the accumulator. A read never changes memory.
- R6: Opcode 0x02 (add) sets the accumulator to its value plus the word at the operand address, modulo 2^32.
- R7: Opcode 0x03 (store) performs exactly one write of the accumulator to the operand address. `mem_wdata` and `mem_addr` stay stable while the write waits.
- R8: Opcode 0x04 adds 1 to the accumulator and opcode 0x05 subtracts 1, both modulo 2^32, and neither touches memory beyond its own fetch.
- R9: Opcode 0x06 (jump) loads the program counter from the address field, so the next fetch is at that address.
- R10: Opcode 0xFF sets `halted` with `illegal_op` at 0. Once halted, the core issues no read or write until reset.
- R11: Any other opcode halts the core with `illegal_op` set to 1 and performs no memory operand access.
- R12: A strobe that meets `mem_ready` low stays high in the next cycle with the same address. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 24 | Memory word address, from the address register |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_wdata | output | 32 | Write data, from the data register |
| mem_rdata | input | 32 | Read data, sampled when ready is high |
| mem_ready | input | 1 | Memory completes the pending access |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stop was caused by an undefined opcode |

## Verification
Short programs run from a start address other than zero, against a memory that answers either at once or after several wait cycles. A load, add and store chain shows the ordering of fetches and operand reads and proves that reads leave memory intact. An add that crosses 2^32, combined with the slow memory, separates correct wrap arithmetic and wait handling from data captured too early. A decrement below zero and a jump over a store separate the zero-address and control-transfer operations from memory-touching ones. A program that reaches an undefined code tells an illegal stop apart from a normal halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    parameter int WORD_W = 32;
    parameter int OP_W   = 8;
    parameter int ADDR_W = WORD_W - OP_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [OP_W-1:0] OPC_ADD   = 8'h02;
    localparam logic [OP_W-1:0] OPC_STORE = 8'h03;
    localparam logic [OP_W-1:0] OPC_INC   = 8'h04;
    localparam logic [OP_W-1:0] OPC_DEC   = 8'h05;
    localparam logic [OP_W-1:0] OPC_JMP   = 8'h06;
    localparam logic [OP_W-1:0] OPC_HALT  = 8'hFF;

    typedef enum logic [2:0] {
        CLS_LOAD, CLS_ADD, CLS_STORE, CLS_INC, CLS_DEC, CLS_JMP, CLS_HALT, CLS_BAD
    } op_class_e;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR, ST_FETCH_WAIT, ST_LOAD_IR, ST_DECODE,
        ST_OPND_WAIT, ST_EXEC, ST_STORE_WAIT, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ACC_HOLD, ACC_LOAD, ACC_ADD, ACC_INC, ACC_DEC
    } acc_op_e;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_ir;
        logic    mdr_from_mem;
        logic    mdr_from_acc;
        logic    ir_load;
        logic    pc_inc;
        logic    pc_jump;
        acc_op_e acc_op;
        logic    rd;
        logic    wr;
    } ctrl_t;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic op_class_e classify(input logic [OP_W-1:0] opc);
        case (opc)
            OPC_LOAD:  return CLS_LOAD;
            OPC_ADD:   return CLS_ADD;
            OPC_STORE: return CLS_STORE;
            OPC_INC:   return CLS_INC;
            OPC_DEC:   return CLS_DEC;
            OPC_JMP:   return CLS_JMP;
            OPC_HALT:  return CLS_HALT;
            default:   return CLS_BAD;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] acc_next(input acc_op_e op,
                                                   input logic [WORD_W-1:0] acc,
                                                   input logic [WORD_W-1:0] mdr);
        case (op)
            ACC_LOAD: return mdr;
            ACC_ADD:  return acc + mdr;
            ACC_INC:  return acc + 1'b1;
            ACC_DEC:  return acc - 1'b1;
            default:  return acc;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            mem_ready,
    output ctrl_t           ctl,
    output logic            halted,
    output logic            illegal_op
);
    state_e    st_q, st_n;
    op_class_e cls;
    logic      ill_q;

    assign cls = classify(opcode);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FETCH_ADDR;
            ill_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_DECODE && cls == CLS_BAD) ill_q <= 1'b1;
        end
    end

    always_comb begin
        ctl  = '0;
        st_n = st_q;
        case (st_q)
            ST_FETCH_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                st_n = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                ctl.rd = 1'b1;
                if (mem_ready) begin
                    ctl.mdr_from_mem = 1'b1;
                    st_n = ST_LOAD_IR;
                end
            end
            ST_LOAD_IR: begin
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
                st_n = ST_DECODE;
            end
            ST_DECODE: begin
                case (cls)
                    CLS_LOAD, CLS_ADD: begin
                        ctl.mar_from_ir = 1'b1;
                        st_n = ST_OPND_WAIT;
                    end
                    CLS_STORE: begin
                        ctl.mar_from_ir  = 1'b1;
                        ctl.mdr_from_acc = 1'b1;
                        st_n = ST_STORE_WAIT;
                    end
                    CLS_INC: begin
                        ctl.acc_op = ACC_INC;
                        st_n = ST_FETCH_ADDR;
                    end
                    CLS_DEC: begin
                        ctl.acc_op = ACC_DEC;
                        st_n = ST_FETCH_ADDR;
                    end
                    CLS_JMP: begin
                        ctl.pc_jump = 1'b1;
                        st_n = ST_FETCH_ADDR;
                    end
                    default: st_n = ST_HALT;
                endcase
            end
            ST_OPND_WAIT: begin
                ctl.rd = 1'b1;
                if (mem_ready) begin
                    ctl.mdr_from_mem = 1'b1;
                    st_n = ST_EXEC;
                end
            end
            ST_EXEC: begin
                ctl.acc_op = (cls == CLS_ADD) ? ACC_ADD : ACC_LOAD;
                st_n = ST_FETCH_ADDR;
            end
            ST_STORE_WAIT: begin
                ctl.wr = 1'b1;
                if (mem_ready) st_n = ST_FETCH_ADDR;
            end
            default: st_n = ST_HALT;
        endcase
    end

    assign halted     = (st_q == ST_HALT);
    assign illegal_op = ill_q;
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mdr,
    output logic [OP_W-1:0]   opcode
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mdr_q;
    logic [WORD_W-1:0] acc_q;
    instr_t            ir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= START_ADDR;
            mar_q <= '0;
            mdr_q <= '0;
            acc_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctl.pc_jump)     pc_q <= ir_q.addr;
            else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;

            if (ctl.mar_from_pc)      mar_q <= pc_q;
            else if (ctl.mar_from_ir) mar_q <= ir_q.addr;

            if (ctl.mdr_from_mem)      mdr_q <= mem_rdata;
            else if (ctl.mdr_from_acc) mdr_q <= acc_q;

            if (ctl.ir_load) ir_q <= instr_t'(mdr_q);

            acc_q <= acc_next(ctl.acc_op, acc_q, mdr_q);
        end
    end

    assign mar    = mar_q;
    assign mdr    = mdr_q;
    assign opcode = ir_q.opcode;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              halted,
    output logic              illegal_op
);
    ctrl_t           ctl;
    logic [OP_W-1:0] opcode;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .mem_ready  (mem_ready),
        .ctl        (ctl),
        .halted     (halted),
        .illegal_op (illegal_op)
    );

    acc_cpu_dp #(.START_ADDR(START_ADDR)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mem_addr),
        .mdr       (mem_wdata),
        .opcode    (opcode)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              halted,
    input logic              illegal_op
);
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_read_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr));

    assert_illegal_halts_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> halted);

    assert_illegal_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> illegal_op);
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .halted     (halted),
    .illegal_op (illegal_op)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    localparam logic [23:0] START = 24'h000008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        halted, illegal_op;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int cnt = 0;
    int n_rd = 0;
    int n_wr = 0;
    int cycles = 0;
    logic [31:0] mem [256];
    logic [23:0] rlog [16];

    always #10 clk = ~clk;

    acc_cpu #(.START_ADDR(START)) u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .halted(halted), .illegal_op(illegal_op)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            mem_ready <= 1'b0; cnt <= 0; n_rd <= 0; n_wr <= 0;
        end else if ((mem_rd || mem_wr) && !mem_ready) begin
            if (cnt >= lat) begin mem_ready <= 1'b1; cnt <= 0; end
            else cnt <= cnt + 1;
        end else begin
            mem_ready <= 1'b0;
            if (mem_ready && mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end
            if (mem_ready && mem_rd) begin
                if (n_rd < 16) rlog[n_rd] <= mem_addr;
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [7:0] op, input logic [23:0] a);
        return {op, a};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic start(input int latency);
        rst = 1'b1;
        lat = latency;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 3000) begin @(negedge clk); n++; end
        check(req, {31'b0, halted}, 32'h1);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[8] = ins(8'hFF, 24'h0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 halted in reset", {31'b0, halted}, 32'h0);
        check("R1 wr in reset", {31'b0, mem_wr}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 illegal after reset", {31'b0, illegal_op}, 32'h0);
        while (!mem_rd) @(negedge clk);
        check("R1/R2 first fetch addr", {8'h0, mem_addr}, {8'h0, START});
        run_to_halt("R10 halt opcode");
        check("R10 illegal clear", {31'b0, illegal_op}, 32'h0);
    endtask

    task automatic t_load_add_store();
        clear_mem();
        mem[8]  = ins(8'h01, 24'h000040);
        mem[9]  = ins(8'h02, 24'h000041);
        mem[10] = ins(8'h03, 24'h000042);
        mem[11] = ins(8'hFF, 24'h000000);
        mem[64] = 32'h1234_5678;
        mem[65] = 32'h0000_0111;
        start(0);
        run_to_halt("R10 run");
        check("R5/R6/R7 stored sum", mem[66], 32'h1234_5789);
        check("R5 operand intact", mem[64], 32'h1234_5678);
        check("R5 operand2 intact", mem[65], 32'h0000_0111);
        check("R7 one write", n_wr, 32'd1);
        check("R3/R4 read0", {8'h0, rlog[0]}, 32'h8);
        check("R4 read1 operand", {8'h0, rlog[1]}, 32'h40);
        check("R3 read2", {8'h0, rlog[2]}, 32'h9);
        check("R4 read3 operand", {8'h0, rlog[3]}, 32'h41);
        check("R3 read4", {8'h0, rlog[4]}, 32'hA);
        check("R3 read5", {8'h0, rlog[5]}, 32'hB);
        check("R10 no illegal", {31'b0, illegal_op}, 32'h0);
    endtask

    task automatic t_wait_wrap();
        clear_mem();
        mem[8]  = ins(8'h01, 24'h000040);
        mem[9]  = ins(8'h02, 24'h000041);
        mem[10] = ins(8'h03, 24'h000042);
        mem[11] = ins(8'hFF, 24'h000000);
        mem[64] = 32'hFFFF_FFFF;
        mem[65] = 32'h0000_0002;
        mem[66] = 32'hAAAA_AAAA;
        start(3);
        run_to_halt("R12 slow run");
        check("R6/R12 wrap sum slow mem", mem[66], 32'h0000_0001);
        check("R7/R12 one write slow", n_wr, 32'd1);
        check("R12 read count slow", n_rd, 32'd6);
    endtask

    task automatic t_incdec();
        clear_mem();
        mem[8]  = ins(8'h01, 24'h000040);
        mem[9]  = ins(8'h05, 24'h000000);
        mem[10] = ins(8'h05, 24'h000000);
        mem[11] = ins(8'h04, 24'h000000);
        mem[12] = ins(8'h03, 24'h000042);
        mem[13] = ins(8'hFF, 24'h000000);
        start(1);
        run_to_halt("R8 run");
        check("R8 dec below zero", mem[66], 32'hFFFF_FFFF);
        check("R8 no operand reads", n_rd, 32'd7);
        check("R8 writes", n_wr, 32'd1);
    endtask

    task automatic t_jump();
        clear_mem();
        mem[8]  = ins(8'h01, 24'h000040);
        mem[9]  = ins(8'h06, 24'h00000C);
        mem[10] = ins(8'h03, 24'h000043);
        mem[11] = ins(8'hFF, 24'h000000);
        mem[12] = ins(8'h04, 24'h000000);
        mem[13] = ins(8'h03, 24'h000042);
        mem[14] = ins(8'hFF, 24'h000000);
        mem[64] = 32'd5;
        mem[67] = 32'hDEAD_BEEF;
        start(0);
        run_to_halt("R9 run");
        check("R9 target path", mem[66], 32'd6);
        check("R9 skipped store", mem[67], 32'hDEAD_BEEF);
        check("R9 fetch after jump", {8'h0, rlog[3]}, 32'hC);
    endtask

    task automatic t_illegal();
        int r0, w0;
        clear_mem();
        mem[8]  = ins(8'h04, 24'h000000);
        mem[9]  = ins(8'h7E, 24'h000042);
        mem[10] = ins(8'h03, 24'h000042);
        mem[66] = 32'h5555_0000;
        start(0);
        run_to_halt("R11 run");
        check("R11 flag", {31'b0, illegal_op}, 32'h1);
        check("R11 no write", n_wr, 32'd0);
        check("R11 reads fetch only", n_rd, 32'd2);
        r0 = n_rd; w0 = n_wr;
        repeat (20) @(negedge clk);
        check("R10 quiet after halt rd", n_rd, r0);
        check("R10 quiet after halt wr", n_wr, w0);
        check("R11 location untouched", mem[66], 32'h5555_0000);
    endtask

    initial begin
        t_reset();
        t_load_add_store();
        t_wait_wrap();
        t_incdec();
        t_jump();
        t_illegal();
        finish_run();
    end
endmodule